// File: doc/BRIEF.md
# Double-Buffered Input Staging Unit

This block stages outgoing messages from a host into a message RAM. It holds two equal banks of 32-bit words. At any moment one bank faces the host and the other faces the copy engine. The host loads a message into its bank through a flat register port. It then writes a target buffer number into the command register. That write exchanges the roles of the two banks and starts a word-by-word copy of the now engine-facing bank into the RAM write port, at the buffer selected by the number.

While a copy runs, the host can prepare the next message. The host can also post one further command, which is held as pending. When the running copy ends, the banks exchange again and the queued copy starts on the next cycle with no gap. If the host writes a data word or a command while a copy runs and a command is already pending, the write is dropped and a sticky error flag is raised. The host clears that flag by writing 1 to it.

Top module: `dbis_input_stage`

## Requirements
- R1: Register map on the host port, with WORDS = 8 and 32-bit words:
  - Addresses 0 to WORDS-1 read and write the words of the host-facing bank.
  - Address WORDS is the command/status register. Its bit 31 is the copy-busy flag, bits 22:16 the active buffer number, bit 15 the pending flag and bits 6:0 the host buffer number. All other bits read 0.
  - Address WORDS+1 holds the error flag in bit 0.
  - Only bits 6:0 of a command write are taken; every other bit of it is ignored.
- R2: A command write while the copy is idle has these effects in the same clock edge:
  - the banks exchange;
  - the active number takes the written value and the host number takes the old active number;
  - the copy-busy flag reads 1 after that edge.
- R3: A copy issues exactly one RAM write per clock for WORDS consecutive clocks. It starts the clock after the accepting edge. The address is buffer number × WORDS + word index, with the index ascending from 0. The data is the matching word of the bank loaded before the command.
- R4: Data writes while only the copy-busy flag is set go to the host-facing bank and are carried by a later copy.
- R5: When a copy ends with nothing pending, the copy-busy flag reads 0 right after the last RAM write clock.
- R6: A command write while a copy is busy and nothing is pending has these effects:
  - it sets the pending flag;
  - it stores the number as the host number;
  - it leaves the host-facing bank in place.
- R7: When a copy ends with a request pending:
  - the banks and numbers exchange again and the pending flag clears;
  - the copy-busy flag stays 1;
  - the next copy's RAM writes follow with no idle clock, giving 2×WORDS back-to-back writes.
- R8: A data or command write while both flags are 1 sets the error flag and changes neither the bank contents nor the host number.
- R9: The error flag stays set until the host writes 1 to bit 0 of address WORDS+1. Writing 0 there leaves it set.
- R10: Reset clears both banks, both numbers, both flags, the error flag and the RAM write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | $clog2(WORDS)+1 | Host register word address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Combinational read data at host_addr |
| ram_we | output | 1 | Message RAM write strobe |
| ram_addr | output | 7+$clog2(WORDS) | Message RAM word address |
| ram_wdata | output | DW | Message RAM write data |

## Verification
Register writes act at the edge that samples them. Status and bank read-back are checked on the falling edge straight after that edge. RAM writes begin the clock after an accepted command and last WORDS clocks, or 2×WORDS clocks when a request is pending. The bench records every RAM write on falling edges together with the length of each run of the strobe. It compares the recorded RAM image and run length only after waiting WORDS+1 or 2×WORDS+2 falling edges. Checks that a rejected write left the buffer untouched are read back while both flags are still set, before the queued exchange can move the banks.

// File: rtl/dbis_pkg.sv
package dbis_pkg;

  localparam int unsigned NUM_W = 7;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_CMD  = 2'd2,
    ACC_ERR  = 2'd3
  } acc_e;

  // RAM word address of a word inside a target buffer
  function automatic int unsigned slot_addr(input logic [NUM_W-1:0] num,
                                            input int unsigned words,
                                            input int unsigned idx);
    return int'(num) * words + idx;
  endfunction

  // Status register image
  function automatic logic [31:0] pack_status(input logic busy_s,
                                              input logic [NUM_W-1:0] num_s,
                                              input logic busy_h,
                                              input logic [NUM_W-1:0] num_h);
    return {busy_s, 8'h00, num_s, busy_h, 8'h00, num_h};
  endfunction

endpackage

// File: rtl/dbis_bank_pair.sv
module dbis_bank_pair #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] host_idx,
  output logic [DW-1:0] host_word,
  input  logic [IW-1:0] eng_idx,
  output logic [DW-1:0] eng_word
);

  logic [DW-1:0] mem [2][WORDS];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < int'(WORDS); w++) mem[b][w] <= '0;
      end else if (wr_en && (host_sel == 1'(b))) begin
        mem[b][wr_idx] <= wr_data;
      end
    end
  end

  assign host_word = mem[host_sel][host_idx];
  assign eng_word  = mem[~host_sel][eng_idx];

endmodule

// File: rtl/dbis_copy_seq.sv
module dbis_copy_seq #(
  parameter int unsigned WORDS = 8,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  output logic [IW-1:0] idx,
  output logic          last
);

  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  assign last = active && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idx <= '0;
    else if (!active || last) idx <= '0;
    else                      idx <= idx + IW'(1);
  end

endmodule

// File: rtl/dbis_cmd_ctrl.sv
module dbis_cmd_ctrl
  import dbis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [NUM_W-1:0] cmd_val,
  input  logic             data_wr,
  input  logic             err_clr,
  input  logic             copy_last,
  output logic             data_wr_ok,
  output logic             host_sel,
  output logic             busy_s,
  output logic             busy_h,
  output logic [NUM_W-1:0] num_s,
  output logic [NUM_W-1:0] num_h,
  output logic             err,
  output logic             ev_accept,
  output logic             ev_queue,
  output logic             ev_done,
  output logic             ev_reject,
  output logic             ev_swap
);

  logic saturated;
  logic pend_now;

  assign saturated  = busy_s && busy_h;
  assign ev_reject  = (cmd_wr || data_wr) && saturated;
  assign ev_accept  = cmd_wr && !busy_s;
  assign ev_queue   = cmd_wr && busy_s && !busy_h;
  assign ev_done    = busy_s && copy_last;
  assign pend_now   = busy_h || ev_queue;
  assign ev_swap    = ev_accept || (ev_done && pend_now);
  assign data_wr_ok = data_wr && !saturated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_sel <= 1'b0;
      busy_s   <= 1'b0;
      busy_h   <= 1'b0;
      num_s    <= '0;
      num_h    <= '0;
    end else if (ev_accept) begin
      host_sel <= ~host_sel;
      busy_s   <= 1'b1;
      num_s    <= cmd_val;
      num_h    <= num_s;
    end else if (ev_done) begin
      if (pend_now) begin
        host_sel <= ~host_sel;
        busy_h   <= 1'b0;
        num_s    <= busy_h ? num_h : cmd_val;
        num_h    <= num_s;
      end else begin
        busy_s   <= 1'b0;
      end
    end else if (ev_queue) begin
      busy_h <= 1'b1;
      num_h  <= cmd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (ev_reject) err <= 1'b1;
    else if (err_clr)   err <= 1'b0;
  end

endmodule

// File: rtl/dbis_input_stage.sv
module dbis_input_stage
  import dbis_pkg::*;
#(
  parameter int unsigned WORDS = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS),
  localparam int unsigned HAW  = IW + 1,
  localparam int unsigned AW   = NUM_W + IW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [DW-1:0]  ram_wdata
);

  localparam logic [HAW-1:0] CMD_ADDR = HAW'(WORDS);
  localparam logic [HAW-1:0] ERR_ADDR = HAW'(WORDS + 1);

  acc_e             acc;
  logic             cmd_wr, data_wr, err_clr, data_wr_ok;
  logic [NUM_W-1:0] cmd_val;
  logic             host_sel, busy_s, busy_h, err;
  logic [NUM_W-1:0] num_s, num_h;
  logic             ev_accept, ev_queue, ev_done, ev_reject, ev_swap;
  logic [IW-1:0]    idx;
  logic             copy_last;
  logic [DW-1:0]    host_word, eng_word;

  always_comb begin
    if (host_addr < CMD_ADDR)       acc = ACC_DATA;
    else if (host_addr == CMD_ADDR) acc = ACC_CMD;
    else if (host_addr == ERR_ADDR) acc = ACC_ERR;
    else                            acc = ACC_NONE;
  end

  assign cmd_wr  = host_we && (acc == ACC_CMD);
  assign data_wr = host_we && (acc == ACC_DATA);
  assign err_clr = host_we && (acc == ACC_ERR) && host_wdata[0];
  assign cmd_val = host_wdata[NUM_W-1:0];

  dbis_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_val   (cmd_val),
    .data_wr   (data_wr),
    .err_clr   (err_clr),
    .copy_last (copy_last),
    .data_wr_ok(data_wr_ok),
    .host_sel  (host_sel),
    .busy_s    (busy_s),
    .busy_h    (busy_h),
    .num_s     (num_s),
    .num_h     (num_h),
    .err       (err),
    .ev_accept (ev_accept),
    .ev_queue  (ev_queue),
    .ev_done   (ev_done),
    .ev_reject (ev_reject),
    .ev_swap   (ev_swap)
  );

  dbis_copy_seq #(.WORDS(WORDS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .active(busy_s),
    .idx   (idx),
    .last  (copy_last)
  );

  dbis_bank_pair #(.WORDS(WORDS), .DW(DW)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_sel (host_sel),
    .wr_en    (data_wr_ok),
    .wr_idx   (host_addr[IW-1:0]),
    .wr_data  (host_wdata),
    .host_idx (host_addr[IW-1:0]),
    .host_word(host_word),
    .eng_idx  (idx),
    .eng_word (eng_word)
  );

  always_comb begin
    unique case (acc)
      ACC_DATA: host_rdata = host_word;
      ACC_CMD:  host_rdata = DW'(pack_status(busy_s, num_s, busy_h, num_h));
      ACC_ERR:  host_rdata = DW'(err);
      default:  host_rdata = '0;
    endcase
  end

  assign ram_we    = busy_s;
  assign ram_addr  = AW'(slot_addr(num_s, WORDS, int'(idx)));
  assign ram_wdata = eng_word;

endmodule

// File: rtl/dbis_input_stage_chk.sv
module dbis_input_stage_chk
  import dbis_pkg::*;
#(
  parameter int unsigned WORDS = 8,
  parameter int unsigned AW    = 10,
  parameter int unsigned IW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ram_we,
  input logic [AW-1:0]    ram_addr,
  input logic             busy_s,
  input logic             busy_h,
  input logic [NUM_W-1:0] num_h,
  input logic [IW-1:0]    idx,
  input logic             err,
  input logic             err_clr,
  input logic             cmd_wr,
  input logic [NUM_W-1:0] cmd_val,
  input logic             ev_accept,
  input logic             ev_done,
  input logic             ev_reject
);

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> ram_we && (ram_addr == AW'(slot_addr($past(cmd_val), WORDS, 0)))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !ev_done) |=> ram_we && (ram_addr == $past(ram_addr) + AW'(1))); // R3

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !busy_h && !cmd_wr) |=> !ram_we); // R5

  AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_h |-> busy_s); // R6

  AST_PEND_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && busy_h) |=> ram_we && !busy_h && (idx == '0)); // R7

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> err && $stable(num_h)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err); // R9

endmodule

bind dbis_input_stage dbis_input_stage_chk #(.WORDS(WORDS), .AW(AW), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .busy_s   (busy_s),
  .busy_h   (busy_h),
  .num_h    (num_h),
  .idx      (idx),
  .err      (err),
  .err_clr  (err_clr),
  .cmd_wr   (cmd_wr),
  .cmd_val  (cmd_val),
  .ev_accept(ev_accept),
  .ev_done  (ev_done),
  .ev_reject(ev_reject)
);

// File: tb/tb_dbis_input_stage.sv
`timescale 1ns/1ps
module tb_dbis_input_stage;

  localparam int WORDS = 8;
  localparam int DW    = 32;
  localparam int IW    = $clog2(WORDS);
  localparam int HAW   = IW + 1;
  localparam int AW    = 7 + IW;
  localparam int NBUF  = 128;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           host_we = 1'b0;
  logic [HAW-1:0] host_addr = '0;
  logic [DW-1:0]  host_wdata = '0;
  logic [DW-1:0]  host_rdata;
  logic           ram_we;
  logic [AW-1:0]  ram_addr;
  logic [DW-1:0]  ram_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] ram_img [NBUF*WORDS];
  int run_len = 0;
  int last_run = 0;

  always #10 clk = ~clk;

  dbis_input_stage #(.WORDS(WORDS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  // RAM image and strobe run length, sampled between edges
  always @(negedge clk) begin
    if (ram_we) begin
      ram_img[int'(ram_addr)] = ram_wdata;
      run_len = run_len + 1;
    end else if (run_len != 0) begin
      last_run = run_len;
      run_len = 0;
    end
  end

  function automatic logic [31:0] pat(int n, int i, int tag);
    return {8'(n), 8'(tag), 8'(i), 8'hC3};
  endfunction

  function automatic logic [31:0] st(bit bs, int ns, bit bh, int nh);
    return {bs, 8'h00, 7'(ns), bh, 8'h00, 7'(nh)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(int a, logic [31:0] d);
    host_we = 1'b1; host_addr = HAW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(int a, output logic [31:0] d);
    host_we = 1'b0; host_addr = HAW'(a);
    #1;
    d = host_rdata;
  endtask

  task automatic chk_region(int n, logic [31:0] exp [WORDS], string req);
    for (int i = 0; i < WORDS; i++)
      chk(ram_img[n*WORDS+i] === exp[i], req, ram_img[n*WORDS+i], exp[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expa [WORDS];
    logic [31:0] expb [WORDS];
    logic [31:0] zer  [WORDS];
    int prev;

    for (int i = 0; i < WORDS; i++) zer[i] = '0;
    for (int i = 0; i < NBUF*WORDS; i++) ram_img[i] = 32'hDEAD_BEEF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    hr(WORDS, v);     chk(v == 32'h0, "R10 status", v, 32'h0);
    hr(WORDS + 1, v); chk(v == 32'h0, "R10 error", v, 32'h0);
    chk(ram_we == 1'b0, "R10 ram_we", 32'(ram_we), 32'h0);
    hr(3, v);         chk(v == 32'h0, "R10 bank word", v, 32'h0);

    // R1/R2: all-ones command, only bits 6:0 taken, reserved read 0
    @(negedge clk);
    hw(WORDS, 32'hFFFF_FFFF);
    hr(WORDS, v); chk(v == st(1, 127, 0, 0), "R1 R2 status after accept", v, st(1, 127, 0, 0));
    repeat (WORDS + 1) @(negedge clk);
    hr(WORDS, v); chk(v == 32'h007F_0000, "R1 R5 status idle", v, 32'h007F_0000);
    chk_region(127, zer, "R3 cleared bank copy");
    prev = 127;

    // R3/R5/R2: sweep every target number
    for (int n = 0; n < NBUF; n++) begin
      for (int i = 0; i < WORDS; i++) begin
        expa[i] = pat(n, i, 1);
        hw(i, expa[i]);
      end
      hr(2, v); chk(v == expa[2], "R1 bank readback", v, expa[2]);
      hw(WORDS, 32'(n));
      hr(WORDS, v); chk(v == st(1, n, 0, prev), "R2 accept numbers", v, st(1, n, 0, prev));
      repeat (WORDS + 1) @(negedge clk);
      chk(last_run == WORDS, "R5 copy length", 32'(last_run), 32'(WORDS));
      hr(WORDS, v); chk(v == st(0, n, 0, prev), "R5 idle after copy", v, st(0, n, 0, prev));
      chk_region(n, expa, "R3 copied words");
      prev = n;
    end

    // R4/R6/R7/R8: pending request, loading during copy, rejected writes
    for (int i = 0; i < WORDS; i++) begin
      expa[i] = pat(10, i, 2);
      hw(i, expa[i]);
    end
    for (int i = 0; i < WORDS; i++) expb[i] = pat(127, i, 1);
    expb[0] = pat(20, 0, 3);
    expb[1] = pat(20, 1, 3);
    hw(WORDS, 32'd10);
    hw(0, expb[0]);
    hw(1, expb[1]);
    hr(1, v); chk(v == expb[1], "R4 load during copy", v, expb[1]);
    hw(WORDS, 32'd20);
    hr(WORDS, v); chk(v == st(1, 10, 1, 20), "R6 pending status", v, st(1, 10, 1, 20));
    hr(0, v); chk(v == expb[0], "R6 no swap on queue", v, expb[0]);
    hw(0, 32'h1234_5678);
    hw(WORDS, 32'd33);
    hr(0, v); chk(v == expb[0], "R8 bank unchanged", v, expb[0]);
    hr(WORDS, v); chk(v == st(1, 10, 1, 20), "R8 number unchanged", v, st(1, 10, 1, 20));
    hr(WORDS + 1, v); chk(v == 32'h1, "R8 error set", v, 32'h1);
    repeat (2 * WORDS + 2) @(negedge clk);
    chk(last_run == 2 * WORDS, "R7 back-to-back copies", 32'(last_run), 32'(2 * WORDS));
    hr(WORDS, v); chk(v == st(0, 20, 0, 10), "R7 final status", v, st(0, 20, 0, 10));
    chk_region(10, expa, "R7 first copy");
    chk_region(20, expb, "R4 R7 queued copy");

    // R9: error clear
    @(negedge clk);
    hw(WORDS + 1, 32'h0);
    hr(WORDS + 1, v); chk(v == 32'h1, "R9 write 0 keeps", v, 32'h1);
    hw(WORDS + 1, 32'h1);
    hr(WORDS + 1, v); chk(v == 32'h0, "R9 write 1 clears", v, 32'h0);

    // R10: reset in the middle of a copy
    @(negedge clk);
    hw(5, 32'hAAAA_5555);
    hw(WORDS, 32'd7);
    hw(WORDS, 32'd8);
    hw(5, 32'h0BAD_0BAD);
    rst_n = 1'b0;
    #1;
    chk(ram_we == 1'b0, "R10 ram_we in reset", 32'(ram_we), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hr(WORDS, v);     chk(v == 32'h0, "R10 status after reset", v, 32'h0);
    hr(WORDS + 1, v); chk(v == 32'h0, "R10 error after reset", v, 32'h0);
    hr(5, v);         chk(v == 32'h0, "R10 host bank after reset", v, 32'h0);
    hw(WORDS, 32'd1);
    hr(5, v);         chk(v == 32'h0, "R10 other bank after reset", v, 32'h0);
    repeat (WORDS + 1) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule